// File: doc/BRIEF.md
# Privilege-Masked Protection Register Bank

This block holds three 64-bit special-purpose registers. The first is a storage key mask, which later stages use to decide which storage keys software may touch. The other two are limit registers: a user limit and a supervisor limit. They control which bits of the key mask, and of the user limit itself, software below the hypervisor may change. The block has a single register-write port with a register number, 64-bit data and a strobe. It also has a combinational read port and two privilege inputs, a user flag and a hypervisor flag.

A write never simply replaces a register. It merges the new data into the old value under a mask, and the current privilege level chooses that mask. User state uses the user limit. Supervisor state uses the supervisor limit. Hypervisor state writes all bits. The key mask can be reached under two register numbers: number 13 is open to user state and number 29 is privileged. Any access that the privilege level does not allow, and any unknown register number, raises a one-cycle fault and changes no register.

Top module: `kmr_bank`

## Requirements
- R1: A legal write to a register stores (old AND NOT mask) OR (data AND mask). Bits outside the mask keep their old value.
- R2: A key-mask write in user state (isUser=1, whatever isHyp is) is masked by the user limit register.
- R3: A key-mask write in supervisor state (isUser=0, isHyp=0), through number 13 or number 29, is masked by the supervisor limit register.
- R4: In hypervisor state (isUser=0, isHyp=1), writes to the key mask and to the user limit replace all 64 bits.
- R5: A user-limit write (number 157) in supervisor state is masked by the supervisor limit register.
- R6: Register numbers 13 and 29 both address the same key-mask storage, for reads and for writes.
- R7: In user state, a read or write of number 29 or of the user limit is refused. It raises the fault and leaves every register unchanged.
- R8: The supervisor limit (number 349) can be read or written only in hypervisor state, where a write replaces all bits. Any other access to it faults and changes nothing.
- R9: An access to any other register number faults. The fault output is registered: it is high for exactly the cycle after the clock edge that samples the illegal access, and it drops again after a legal or idle cycle.
- R10: A legal read returns the stored value unmasked and combinationally. A read of the register being written in the same cycle returns the value from before the write. An illegal read, or rdEn low, returns zero.
- R11: A synchronous active-high reset clears all three registers to zero and clears the fault output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| isUser | input | 1 | Current state is user |
| isHyp | input | 1 | Current state is hypervisor (ignored when isUser=1) |
| wrEn | input | 1 | Write strobe |
| wrNum | input | 10 | Register number of the write |
| wrData | input | 64 | Write data |
| rdEn | input | 1 | Read enable |
| rdNum | input | 10 | Register number of the read |
| rdData | output | 64 | Read data, combinational |
| fault | output | 1 | Illegal-access flag, one cycle after the access |

## Verification
Read data is combinational, so the bench samples it 1 ns after driving the read, within the same cycle. This is how it sees the pre-write value when a read and a write of one register coincide. A write lands at the next rising edge, and the fault flag also comes from a register loaded at that edge. The bench therefore checks both at the falling edge that follows the access. It confirms that the flag clears one cycle later. Expected register contents come from a merge function in the bench applied to the limit values that the bench itself wrote earlier. Those contents are read back in hypervisor state, where every register is readable.

// File: rtl/kmr_pkg.sv
package kmr_pkg;

  typedef enum logic [1:0] {
    PRIV_USER = 2'd0,
    PRIV_SUP  = 2'd1,
    PRIV_HYP  = 2'd2
  } priv_e;

  typedef enum logic [1:0] {
    MASK_FULL = 2'd0,
    MASK_ULIM = 2'd1,
    MASK_SLIM = 2'd2
  } maskSel_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_KEY  = 2'd1,
    TGT_ULIM = 2'd2,
    TGT_SLIM = 2'd3
  } target_e;

  typedef struct packed {
    logic     wrKey;
    logic     wrUlim;
    logic     wrSlim;
    maskSel_e maskSel;
    target_e  rdSel;
  } ctrl_t;

endpackage

// File: rtl/kmr_ctrl.sv
module kmr_ctrl
  import kmr_pkg::*;
#(
  parameter int NUM_W        = 10,
  parameter int NUM_KEY_OPEN = 13,
  parameter int NUM_KEY_PRIV = 29,
  parameter int NUM_ULIM     = 157,
  parameter int NUM_SLIM     = 349
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             isUser,
  input  logic             isHyp,
  input  logic             wrEn,
  input  logic [NUM_W-1:0] wrNum,
  input  logic             rdEn,
  input  logic [NUM_W-1:0] rdNum,
  output ctrl_t            ctl,
  output logic             fault
);

  localparam logic [NUM_W-1:0] KeyOpenNum = NUM_W'(NUM_KEY_OPEN);
  localparam logic [NUM_W-1:0] KeyPrivNum = NUM_W'(NUM_KEY_PRIV);
  localparam logic [NUM_W-1:0] UlimNum    = NUM_W'(NUM_ULIM);
  localparam logic [NUM_W-1:0] SlimNum    = NUM_W'(NUM_SLIM);

  priv_e   priv;
  target_e wrTgt;
  target_e rdTgt;
  logic    wrOk;
  logic    rdOk;
  logic    faultNxt;

  function automatic target_e decodeNum(input logic [NUM_W-1:0] n);
    if (n == KeyOpenNum || n == KeyPrivNum) return TGT_KEY;
    if (n == UlimNum) return TGT_ULIM;
    if (n == SlimNum) return TGT_SLIM;
    return TGT_NONE;
  endfunction

  function automatic logic permitted(input logic [NUM_W-1:0] n, input target_e t,
                                     input priv_e p);
    case (t)
      TGT_KEY:  return !(p == PRIV_USER && n == KeyPrivNum);
      TGT_ULIM: return p != PRIV_USER;
      TGT_SLIM: return p == PRIV_HYP;
      default:  return 1'b0;
    endcase
  endfunction

  always_comb begin
    if (isUser)     priv = PRIV_USER;
    else if (isHyp) priv = PRIV_HYP;
    else            priv = PRIV_SUP;
  end

  always_comb begin
    wrTgt = decodeNum(wrNum);
    rdTgt = decodeNum(rdNum);
    wrOk  = permitted(wrNum, wrTgt, priv);
    rdOk  = permitted(rdNum, rdTgt, priv);
  end

  always_comb begin
    ctl.wrKey  = wrEn && wrOk && (wrTgt == TGT_KEY);
    ctl.wrUlim = wrEn && wrOk && (wrTgt == TGT_ULIM);
    ctl.wrSlim = wrEn && wrOk && (wrTgt == TGT_SLIM);
    case (priv)
      PRIV_USER: ctl.maskSel = MASK_ULIM;
      PRIV_SUP:  ctl.maskSel = MASK_SLIM;
      default:   ctl.maskSel = MASK_FULL;
    endcase
    ctl.rdSel = (rdEn && rdOk) ? rdTgt : TGT_NONE;
    faultNxt  = (wrEn && !wrOk) || (rdEn && !rdOk);
  end

  always_ff @(posedge clk) begin
    if (rst) fault <= 1'b0;
    else     fault <= faultNxt;
  end

  AST_USER_NO_PRIV_WR: assert property (@(posedge clk) disable iff (rst)
    (isUser && wrEn && (wrNum == KeyPrivNum || wrNum == UlimNum))
      |-> !(ctl.wrKey || ctl.wrUlim)); // R7

  AST_SLIM_HYP_ONLY: assert property (@(posedge clk) disable iff (rst)
    (ctl.wrSlim || ctl.rdSel == TGT_SLIM) |-> (isHyp && !isUser)); // R8

  AST_HYP_FULL_MASK: assert property (@(posedge clk) disable iff (rst)
    (isHyp && !isUser && (ctl.wrKey || ctl.wrUlim)) |-> ctl.maskSel == MASK_FULL); // R4

  AST_FAULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !(ctl.wrKey || ctl.wrUlim || ctl.wrSlim)) |=> fault); // R9

endmodule

// File: rtl/kmr_dpath.sv
module kmr_dpath
  import kmr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int NREG   = 3;
  localparam int IDX_KEY  = 0;
  localparam int IDX_ULIM = 1;
  localparam int IDX_SLIM = 2;

  logic [DATA_W-1:0] regQ  [NREG];
  logic [NREG-1:0]   wrStb;
  logic [DATA_W-1:0] mask;

  always_comb begin
    wrStb[IDX_KEY]  = ctl.wrKey;
    wrStb[IDX_ULIM] = ctl.wrUlim;
    wrStb[IDX_SLIM] = ctl.wrSlim;
    case (ctl.maskSel)
      MASK_ULIM: mask = regQ[IDX_ULIM];
      MASK_SLIM: mask = regQ[IDX_SLIM];
      default:   mask = '1;
    endcase
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DATA_W-1:0] merged;

    always_comb merged = (regQ[i] & ~mask) | (wrData & mask);

    always_ff @(posedge clk) begin
      if (rst)           regQ[i] <= '0;
      else if (wrStb[i]) regQ[i] <= merged;
    end

    AST_HOLD_UNWRITTEN: assert property (@(posedge clk) disable iff (rst)
      !wrStb[i] |=> $stable(regQ[i])); // R7

    AST_MASK_OUTSIDE_KEPT: assert property (@(posedge clk) disable iff (rst)
      wrStb[i] |=> ((regQ[i] & ~$past(mask)) == ($past(regQ[i]) & ~$past(mask)))); // R1

    AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> regQ[i] == '0); // R11
  end

  always_comb begin
    case (ctl.rdSel)
      TGT_KEY:  rdData = regQ[IDX_KEY];
      TGT_ULIM: rdData = regQ[IDX_ULIM];
      TGT_SLIM: rdData = regQ[IDX_SLIM];
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/kmr_bank.sv
module kmr_bank
  import kmr_pkg::*;
#(
  parameter int DATA_W       = 64,
  parameter int NUM_W        = 10,
  parameter int NUM_KEY_OPEN = 13,
  parameter int NUM_KEY_PRIV = 29,
  parameter int NUM_ULIM     = 157,
  parameter int NUM_SLIM     = 349
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              isUser,
  input  logic              isHyp,
  input  logic              wrEn,
  input  logic [NUM_W-1:0]  wrNum,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [NUM_W-1:0]  rdNum,
  output logic [DATA_W-1:0] rdData,
  output logic              fault
);

  ctrl_t ctl;

  kmr_ctrl #(
    .NUM_W(NUM_W), .NUM_KEY_OPEN(NUM_KEY_OPEN), .NUM_KEY_PRIV(NUM_KEY_PRIV),
    .NUM_ULIM(NUM_ULIM), .NUM_SLIM(NUM_SLIM)
  ) u_ctrl (
    .clk(clk), .rst(rst), .isUser(isUser), .isHyp(isHyp),
    .wrEn(wrEn), .wrNum(wrNum), .rdEn(rdEn), .rdNum(rdNum),
    .ctl(ctl), .fault(fault)
  );

  kmr_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst(rst), .ctl(ctl), .wrData(wrData), .rdData(rdData)
  );

  AST_FAULT_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (!wrEn && !rdEn) |=> !fault); // R9

endmodule

// File: tb/sim_kmr_bank.sv
`timescale 1ns/1ps
module sim_kmr_bank;

  localparam logic [9:0] NK  = 10'd13;
  localparam logic [9:0] NKP = 10'd29;
  localparam logic [9:0] NUL = 10'd157;
  localparam logic [9:0] NSL = 10'd349;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        isUser = 1'b0, isHyp = 1'b1;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [9:0]  wrNum = '0, rdNum = '0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;
  logic        fault;

  int checks = 0;
  int errors = 0;
  logic [63:0] mKey = '0, mUl = '0, mSl = '0;

  always #2.5 clk = ~clk;

  kmr_bank u0 (
    .clk(clk), .rst(rst), .isUser(isUser), .isHyp(isHyp),
    .wrEn(wrEn), .wrNum(wrNum), .wrData(wrData),
    .rdEn(rdEn), .rdNum(rdNum), .rdData(rdData), .fault(fault)
  );

  function automatic logic [63:0] merge(input logic [63:0] o, d, m);
    return (o & ~m) | (d & m);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [9:0] n, input logic [63:0] d,
                         input logic u, h, expFault, input string tag);
    @(negedge clk);
    isUser = u; isHyp = h; wrEn = 1'b1; wrNum = n; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    check({tag, " fault"}, {63'd0, fault}, {63'd0, expFault});
  endtask

  task automatic doRead(input logic [9:0] n, input logic u, h, expFault,
                        output logic [63:0] v, input string tag);
    @(negedge clk);
    isUser = u; isHyp = h; rdEn = 1'b1; rdNum = n;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
    check({tag, " rd fault"}, {63'd0, fault}, {63'd0, expFault});
  endtask

  task automatic expectAll(input string tag);
    logic [63:0] v;
    doRead(NK, 1'b0, 1'b1, 1'b0, v, tag); check({tag, " key"}, v, mKey);
    doRead(NUL, 1'b0, 1'b1, 1'b0, v, tag); check({tag, " ulim"}, v, mUl);
    doRead(NSL, 1'b0, 1'b1, 1'b0, v, tag); check({tag, " slim"}, v, mSl);
  endtask

  task automatic testReset();
    check("R11 fault after reset", {63'd0, fault}, 64'd0);
    expectAll("R11 reset");
  endtask

  task automatic testHypFull();
    mSl = 64'h00FF_00FF_F0F0_0FF0;
    doWrite(NSL, mSl, 1'b0, 1'b1, 1'b0, "R8 hyp slim");
    mUl = 64'h0F0F_0F0F_FFFF_0000;
    doWrite(NUL, mUl, 1'b0, 1'b1, 1'b0, "R4 hyp ulim");
    mKey = 64'h1234_5678_9ABC_DEF0;
    doWrite(NKP, mKey, 1'b0, 1'b1, 1'b0, "R4 hyp key");
    expectAll("R4 R8 hyp full");
  endtask

  task automatic testSupUlim();
    logic [63:0] d = 64'hFFFF_FFFF_0000_0000;
    mUl = merge(mUl, d, mSl);
    doWrite(NUL, d, 1'b0, 1'b0, 1'b0, "R5 sup ulim");
    expectAll("R5 R1 sup ulim merge");
  endtask

  task automatic testUserKey();
    logic [63:0] d = 64'hA5A5_5A5A_C3C3_3C3C;
    mKey = merge(mKey, d, mUl);
    doWrite(NK, d, 1'b1, 1'b0, 1'b0, "R2 user key");
    expectAll("R2 user key merge");
    d = 64'hFFFF_0000_FFFF_0000;
    mKey = merge(mKey, d, mUl);
    doWrite(NK, d, 1'b1, 1'b1, 1'b0, "R2 user+hyp key");
    expectAll("R2 user wins over hyp");
  endtask

  task automatic testSupKey();
    logic [63:0] d = 64'h0000_FFFF_1111_EEEE;
    mKey = merge(mKey, d, mSl);
    doWrite(NKP, d, 1'b0, 1'b0, 1'b0, "R3 sup key 29");
    expectAll("R3 sup key 29");
    d = 64'hDEAD_BEEF_0BAD_F00D;
    mKey = merge(mKey, d, mSl);
    doWrite(NK, d, 1'b0, 1'b0, 1'b0, "R3 sup key 13");
    expectAll("R3 sup key 13");
  endtask

  task automatic testAlias();
    logic [63:0] v;
    mKey = 64'h0123_4567_89AB_CDEF;
    doWrite(NKP, mKey, 1'b0, 1'b1, 1'b0, "R6 write 29");
    doRead(NK, 1'b1, 1'b0, 1'b0, v, "R6 user read 13");
    check("R6 alias 13 sees 29", v, mKey);
    mKey = 64'hFEDC_BA98_7654_3210;
    doWrite(NK, mKey, 1'b0, 1'b1, 1'b0, "R6 write 13");
    doRead(NKP, 1'b0, 1'b0, 1'b0, v, "R6 sup read 29");
    check("R6 alias 29 sees 13", v, mKey);
  endtask

  task automatic testUserIllegal();
    logic [63:0] v;
    doWrite(NKP, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1, "R7 user wr 29");
    doWrite(NUL, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1, "R7 user wr ulim");
    doRead(NUL, 1'b1, 1'b0, 1'b1, v, "R7 user rd ulim");
    check("R10 illegal read zero", v, 64'd0);
    doRead(NKP, 1'b1, 1'b0, 1'b1, v, "R7 user rd 29");
    check("R10 illegal read 29 zero", v, 64'd0);
    expectAll("R7 unchanged");
  endtask

  task automatic testSlimGuard();
    logic [63:0] v;
    doWrite(NSL, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b1, "R8 sup wr slim");
    doWrite(NSL, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b1, "R8 user wr slim");
    doRead(NSL, 1'b0, 1'b0, 1'b1, v, "R8 sup rd slim");
    check("R8 sup rd slim zero", v, 64'd0);
    expectAll("R8 unchanged");
  endtask

  task automatic testUnknown();
    doWrite(10'd100, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 1'b1, "R9 unknown wr");
    @(negedge clk);
    check("R9 fault drops", {63'd0, fault}, 64'd0);
    expectAll("R9 unchanged");
  endtask

  task automatic testSameCycle();
    logic [63:0] d = 64'h5555_AAAA_5555_AAAA;
    @(negedge clk);
    isUser = 1'b0; isHyp = 1'b1;
    wrEn = 1'b1; wrNum = NK; wrData = d; rdEn = 1'b1; rdNum = NK;
    #1 check("R10 same-cycle old value", rdData, mKey);
    @(negedge clk);
    wrEn = 1'b0;
    mKey = d;
    check("R10 after edge new value", rdData, mKey);
    rdEn = 1'b0;
    #1 check("R10 rdEn low zero", rdData, 64'd0);
  endtask

  task automatic testMidReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    mKey = '0; mUl = '0; mSl = '0;
    check("R11 fault cleared", {63'd0, fault}, 64'd0);
    expectAll("R11 mid reset");
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testHypFull();
    testSupUlim();
    testUserKey();
    testSupKey();
    testUserIllegal();
    testSlimGuard();
    testUnknown();
    testSameCycle();
    testAlias();
    testMidReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule